// File: doc/BRIEF.md
# UART Two-Stage Baud Tick Generator

This block produces the two timing strobes a UART needs: a bit-sample tick that paces the receiver's oversampling, and a baud tick that marks each bit period. The sample tick comes from a 16-bit prescaler that counts cycles of a selectable source. That source is either every clock cycle or an internal one-in-eight enable. An 8-bit divider then passes one of every (divider + 1) sample ticks on as a baud tick. The resulting rates are f_src / prescaler for sampling and f_src / ((divider + 1) × prescaler) for bits.

The two configuration values are held inside the block and loaded through separate write strobes. A prescaler of zero stops both ticks. A divider value below four is refused and the held value stays in place. Every accepted write restarts the source divider, the prescaler and the divider from zero, so the new rate starts on a clean boundary with no partial period from the old settings. The shift registers and the majority vote that use these ticks live outside the block.

Top module: `uart_baud_gen`

## Requirements
- R1: After a synchronous reset the prescaler holds 651 and the divider holds 15. With the direct source, counting from the last clock edge with reset high, the first sample tick is seen after 651 edges and the first baud tick after 10416 edges.
- R2: With prescaler value P ≥ 1 and source stride S, sample_tick is high for one cycle after every P×S-th clock edge following a restart, and low otherwise.
- R3: With a prescaler of 1, sample_tick is high for every enabled source cycle: every cycle with the direct source.
- R4: A prescaler value of 0 keeps both sample_tick and baud_tick low for as long as it is held.
- R5: src_sel = 0 selects the direct source (S = 1). src_sel = 1 selects the one-in-eight source (S = 8), whose first enable falls on the eighth cycle after a restart. src_sel is sampled continuously and is changed together with a prescaler write.
- R6: baud_tick is high on exactly every (D+1)-th sample tick after a restart, where D is the divider value, and only in a cycle in which sample_tick is also high.
- R7: A divider write with a value below 4 is ignored. The held divider does not change, the counters are not restarted, and the tick phase continues as before.
- R8: Divider values from 4 to 255 are accepted, including both bounds.
- R9: An accepted write (any prescaler write, or a divider write of 4 or more) clears every counter and both tick outputs at that edge. The next sample tick follows P×S edges later.
- R10: When both strobes are high in the same cycle, both values are taken and a single restart occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Source select: 0 every cycle, 1 one-in-eight enable |
| presc_wr | input | 1 | Prescaler write strobe |
| presc_wdata | input | 16 | Prescaler write value (0 stops ticking) |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | 8 | Divider write value (below 4 is ignored) |
| sample_tick | output | 1 | One-cycle bit-sample strobe |
| baud_tick | output | 1 | One-cycle baud strobe, coincident with a sample tick |

## Verification
A wrong count in the source divider or the prescaler shows up as a sample tick that lands one or more cycles early or late. This is visible at the first tick after a restart, at most P×S cycles in. A divider counter or held divider value that goes wrong moves baud_tick off the expected multiple of the sample period. An ignored write that leaked into the registers or into a restart shifts the phase of the very next tick. The bench therefore compares both outputs against the arithmetic expectation on every cycle of each window.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

    localparam int PRESC_W = 16;
    localparam int DIV_W   = 8;

    localparam logic [PRESC_W-1:0] PRESC_RST = 16'd651;
    localparam logic [DIV_W-1:0]   DIV_RST   = 8'd15;
    localparam logic [DIV_W-1:0]   DIV_MIN   = 8'd4;

    typedef enum logic {
        SRC_DIRECT = 1'b0,
        SRC_SLOW   = 1'b1
    } src_mode_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [DIV_W-1:0]   div;
    } baud_cfg_t;

    function automatic logic div_value_ok(input logic [DIV_W-1:0] v);
        return v >= DIV_MIN;
    endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import uart_baud_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               presc_wr,
    input  logic [PRESC_W-1:0] presc_wdata,
    input  logic               div_wr,
    input  logic [DIV_W-1:0]   div_wdata,
    output baud_cfg_t          cfg,
    output logic               restart
);
    logic div_take;

    assign div_take = div_wr && div_value_ok(div_wdata);
    assign restart  = presc_wr || div_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.presc <= PRESC_RST;
            cfg.div   <= DIV_RST;
        end else begin
            if (presc_wr) cfg.presc <= presc_wdata;
            if (div_take) cfg.div   <= div_wdata;
        end
    end

    // divider register never holds a refused value
    assert_div_legal_R8: assert property (@(posedge clk) disable iff (rst)
        cfg.div >= DIV_MIN);

    // a refused divider write leaves the held value alone
    assert_div_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (div_wr && !div_value_ok(div_wdata) && !presc_wr) |=> $stable(cfg.div));

endmodule

// File: rtl/baud_src_enable.sv
module baud_src_enable #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic src_sel,
    output logic src_en
);
    import uart_baud_pkg::*;

    logic slow_en;

    generate
        if (RATIO <= 1) begin : g_no_div
            assign slow_en = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(RATIO);
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
            logic [CW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || restart)   phase <= '0;
                else if (phase == LAST) phase <= '0;
                else                  phase <= phase + 1'b1;
            end

            assign slow_en = (phase == LAST);
        end
    endgenerate

    assign src_en = (src_mode_e'(src_sel) == SRC_SLOW) ? slow_en : 1'b1;

    generate
        if (RATIO > 1) begin : g_chk
            // slow source never enables two cycles in a row
            assert_slow_gap_R5: assert property (@(posedge clk) disable iff (rst)
                (src_sel && $past(src_sel) && src_en) |-> !$past(src_en));
        end
    endgenerate

endmodule

// File: rtl/baud_mod_counter.sv
module baud_mod_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic         fire,
    output logic         tick_q
);
    logic [W-1:0] cnt;

    assign fire = step && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt    <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= fire;
            if (fire)      cnt <= '0;
            else if (step) cnt <= cnt + 1'b1;
        end
    end

    // count stays within the current modulus
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_baud_pkg::*;
#(
    parameter int SRC_RATIO = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               src_sel,
    input  logic               presc_wr,
    input  logic [PRESC_W-1:0] presc_wdata,
    input  logic               div_wr,
    input  logic [DIV_W-1:0]   div_wdata,
    output logic               sample_tick,
    output logic               baud_tick
);
    baud_cfg_t cfg;
    logic      restart;
    logic      src_en;
    logic      presc_live;
    logic      samp_fire;
    logic      baud_fire;

    baud_cfg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .presc_wr    (presc_wr),
        .presc_wdata (presc_wdata),
        .div_wr      (div_wr),
        .div_wdata   (div_wdata),
        .cfg         (cfg),
        .restart     (restart)
    );

    baud_src_enable #(.RATIO(SRC_RATIO)) u_src (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .src_sel (src_sel),
        .src_en  (src_en)
    );

    assign presc_live = (cfg.presc != '0);

    baud_mod_counter #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (src_en && presc_live),
        .last    (cfg.presc - 1'b1),
        .fire    (samp_fire),
        .tick_q  (sample_tick)
    );

    baud_mod_counter #(.W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (samp_fire),
        .last    (cfg.div),
        .fire    (baud_fire),
        .tick_q  (baud_tick)
    );

    assert_baud_on_sample_R6: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> sample_tick);

    assert_zero_stops_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg.presc == '0) |=> (!sample_tick && !baud_tick));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!sample_tick && !baud_tick));

endmodule

// File: tb/uart_baud_gen_bench.sv
module uart_baud_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_sel = 1'b0;
    logic        presc_wr = 1'b0;
    logic [15:0] presc_wdata = '0;
    logic        div_wr = 1'b0;
    logic [7:0]  div_wdata = '0;
    logic        sample_tick;
    logic        baud_tick;

    int n = 0;
    int exp_p = 651;
    int exp_d = 15;
    int exp_s = 1;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_baud_gen u_uart_baud_gen (
        .clk         (clk),
        .rst         (rst),
        .src_sel     (src_sel),
        .presc_wr    (presc_wr),
        .presc_wdata (presc_wdata),
        .div_wr      (div_wr),
        .div_wdata   (div_wdata),
        .sample_tick (sample_tick),
        .baud_tick   (baud_tick)
    );

    function automatic bit want_sample(int k);
        if (exp_p == 0 || k <= 0) return 1'b0;
        return (k % (exp_p * exp_s)) == 0;
    endfunction

    function automatic bit want_baud(int k);
        if (!want_sample(k)) return 1'b0;
        return (k % (exp_p * exp_s * (exp_d + 1))) == 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (n=%0d P=%0d D=%0d S=%0d)",
                     req, what, act, expv, n, exp_p, exp_d, exp_s);
        end
    endtask

    task automatic window(int cycles, string req);
        bit s_bad = 1'b0;
        bit b_bad = 1'b0;
        int s_act = 0, s_exp = 0, b_act = 0, b_exp = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            n++;
            if (sample_tick !== want_sample(n) && !s_bad) begin
                s_bad = 1'b1; s_act = int'(sample_tick); s_exp = int'(want_sample(n));
                $display("  sample mismatch at n=%0d", n);
            end
            if (baud_tick !== want_baud(n) && !b_bad) begin
                b_bad = 1'b1; b_act = int'(baud_tick); b_exp = int'(want_baud(n));
                $display("  baud mismatch at n=%0d", n);
            end
        end
        check(!s_bad, req, "sample_tick", s_act, s_exp);
        check(!b_bad, req, "baud_tick", b_act, b_exp);
    endtask

    task automatic check_cleared(string req);
        check(sample_tick === 1'b0, req, "sample_tick after restart", int'(sample_tick), 0);
        check(baud_tick === 1'b0, req, "baud_tick after restart", int'(baud_tick), 0);
    endtask

    task automatic wr_presc(int val, bit sel);
        src_sel = sel;
        presc_wr = 1'b1;
        presc_wdata = 16'(val);
        @(negedge clk);
        presc_wr = 1'b0;
        n = 0;
        exp_p = val;
        exp_s = sel ? 8 : 1;
        check_cleared("R9");
    endtask

    task automatic wr_div(int val);
        div_wr = 1'b1;
        div_wdata = 8'(val);
        if (val >= 4) begin
            @(negedge clk);
            div_wr = 1'b0;
            n = 0;
            exp_d = val;
            check_cleared("R9");
        end else begin
            window(1, "R7");
            div_wr = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int dl[3] = '{4, 5, 7};
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n = 0;
        check(sample_tick === 1'b0, "R1", "sample_tick in reset", int'(sample_tick), 0);
        check(baud_tick === 1'b0, "R1", "baud_tick in reset", int'(baud_tick), 0);
        window(10420, "R1");

        for (int sel = 0; sel < 2; sel++) begin
            for (int p = 1; p <= 4; p++) begin
                for (int di = 0; di < 3; di++) begin
                    wr_div(dl[di]);
                    wr_presc(p, sel[0]);
                    window(2 * p * exp_s * (dl[di] + 1) + 3,
                           (p == 1) ? "R3 R5 R6" : "R2 R5 R6");
                end
            end
        end

        // R10: both strobes in one cycle
        src_sel = 1'b0;
        presc_wr = 1'b1; presc_wdata = 16'd3;
        div_wr = 1'b1;   div_wdata = 8'd6;
        @(negedge clk);
        presc_wr = 1'b0; div_wr = 1'b0;
        n = 0; exp_p = 3; exp_d = 6; exp_s = 1;
        check_cleared("R10");
        window(50, "R10");

        // R7: refused divider values keep value and phase
        wr_presc(2, 1'b0);
        wr_div(5);
        window(17, "R7");
        wr_div(3);
        window(60, "R7");
        wr_div(0);
        window(60, "R7");

        // R9: restart in mid-period with the same value
        window(7, "R9");
        wr_presc(2, 1'b0);
        window(40, "R9");

        // R8: upper divider bound
        wr_presc(1, 1'b0);
        wr_div(255);
        window(520, "R8");

        // R4: prescaler zero stops everything
        wr_presc(0, 1'b0);
        window(600, "R4");
        wr_presc(1, 1'b1);
        wr_div(4);
        window(90, "R3 R5");

        // R2: largest prescaler
        wr_presc(65535, 1'b0);
        window(65540, "R2");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule